// File: doc/BRIEF.md
# Dual-Address Serial Register Target

This block is an I2C target that answers on two 7-bit target addresses. Each address owns a separate register bank. Each bank holds a set of writable control registers, whose bytes drive enables and settings elsewhere on the chip as parallel outputs. Each bank also holds a few status registers, whose values come from chip inputs and which can only be read.

Two physical clock/data pin pairs reach the block. A select input chooses which pair the target listens to and drives. The other pair is ignored. The select is taken only while no transfer is in progress, so a frame can never move from one pair to the other. Every line passes through a two-flop synchronizer and a glitch filter before the protocol engine sees it.

In a write, the first byte after the address loads a register pointer. Each following byte is stored at the pointer, and the pointer then advances. A read, usually reached through a repeated START, returns bytes from the pointer onward, and the pointer advances after each byte.

Top module: `dual_i2c_target`

## Requirements
- R1: A write to target address 0x2A stores data bytes into bank 0's control registers, and control register k appears on `ctrl0_o[k*8 +: 8]`.
- R2: A write to target address 0x4C stores into bank 1 only, shown on `ctrl1_o`, and bank 0 is left unchanged.
- R3: An address byte that matches neither target address is not acknowledged (the data line stays high in the ACK slot). All bytes up to the next START are then ignored and no register changes.
- R4: The first byte after a write address sets the register pointer. Each later data byte is written at the pointer, and the pointer then advances by one.
- R5: A read after a repeated START returns the byte at the pointer. The pointer advances after every byte, and the read continues for as long as the controller acknowledges.
- R6: Registers 4 and 5 of each bank return that bank's status input bytes (`stat*_i[7:0]` and `stat*_i[15:8]`). A write to them has no effect.
- R7: A read of any register address from 6 upward returns 0x00.
- R8: `pair_sel_i` low selects pair A and high selects pair B. Traffic on the unselected pair gets no acknowledge and changes nothing, and the output enable of that pair stays low.
- R9: A change of `pair_sel_i` during a transfer takes effect only after the STOP. The transfer in progress completes on the original pair.
- R10: A clock pulse lasting 2 system clocks or less is filtered out and does not count as a bit.
- R11: The data output enable changes only while the filtered clock line is low.
- R12: After reset, all control registers read 0 and both data output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pair_sel_i | input | 1 | Pair select: 0 selects pair A, 1 selects pair B |
| scl_a_i | input | 1 | Pair A clock line |
| sda_a_i | input | 1 | Pair A data line as seen on the bus |
| sda_a_oe_o | output | 1 | Pair A open-drain pull-low enable |
| scl_b_i | input | 1 | Pair B clock line |
| sda_b_i | input | 1 | Pair B data line as seen on the bus |
| sda_b_oe_o | output | 1 | Pair B open-drain pull-low enable |
| stat0_i | input | 16 | Bank 0 status bytes (register 4 in the low byte) |
| stat1_i | input | 16 | Bank 1 status bytes (register 4 in the low byte) |
| ctrl0_o | output | 32 | Bank 0 control registers 0..3, register k in byte k |
| ctrl1_o | output | 32 | Bank 1 control registers 0..3, register k in byte k |

## Verification
Some internal faults show up at the ACK slot of the same frame. A wrong bit count or a wrong address compare gives a missing or misplaced acknowledge there. A wrong pointer shows up one byte later, either as a wrong byte read back or as a write landing at a neighbouring offset on the control outputs. A pair-select latch that follows the input while busy shows up mid-frame: the acknowledges stop and the write that was in progress is lost. A filter that passes short pulses shifts every later bit by one position, so the next register write lands corrupted. Every check reads back through the serial bus or the parallel outputs within one transaction of the fault.

// File: rtl/dit_pkg.sv
package dit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } dit_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/dit_line_filter.sv
module dit_line_filter #(
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
        // input has differed for FILT_CYCLES consecutive clocks
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/dit_pair_mux.sv
module dit_pair_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic busy_i,
  input  logic scl_a_i,
  input  logic sda_a_i,
  input  logic scl_b_i,
  input  logic sda_b_i,
  input  logic oe_i,
  output logic scl_o,
  output logic sda_o,
  output logic sda_a_oe_o,
  output logic sda_b_oe_o,
  output logic sel_q_o
);
  logic [1:0] sel_sync_q;
  logic       sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_sync_q <= 2'b00;
      sel_q      <= 1'b0;
    end else begin
      sel_sync_q <= {sel_sync_q[0], sel_i};
      if (!busy_i) sel_q <= sel_sync_q[1];
    end
  end

  assign scl_o      = sel_q ? scl_b_i : scl_a_i;
  assign sda_o      = sel_q ? sda_b_i : sda_a_i;
  assign sda_a_oe_o = oe_i & ~sel_q;
  assign sda_b_oe_o = oe_i & sel_q;
  assign sel_q_o    = sel_q;
endmodule

// File: rtl/dit_proto.sv
module dit_proto
  import dit_pkg::*;
#(
  parameter logic [6:0] ADDR0 = 7'h2A,
  parameter logic [6:0] ADDR1 = 7'h4C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rdata0_i,
  input  logic [BYTE_W-1:0] rdata1_i,
  output logic              oe_o,
  output logic              busy_o,
  output logic              idle_o,
  output logic              bank_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [BYTE_W-1:0] raddr_o
);
  dit_state_e        state_q;
  logic              scl_d, sda_d;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sr_q, tx_q, ptr_q;
  logic              rw_q, ptr_ph_q, mack_q;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [BYTE_W-1:0] rdata;
  logic              hit0, hit1;

  assign scl_rise = scl_i & ~scl_d;
  assign scl_fall = ~scl_i & scl_d;
  assign start_c  = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_c   = scl_i & scl_d & ~sda_d & sda_i;
  assign rdata    = bank_o ? rdata1_i : rdata0_i;
  assign hit0     = (sr_q[7:1] == ADDR0);
  assign hit1     = (sr_q[7:1] == ADDR1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sr_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      ptr_ph_q <= 1'b0;
      mack_q   <= 1'b0;
      oe_o     <= 1'b0;
      busy_o   <= 1'b0;
      bank_o   <= 1'b0;
      wr_en_o  <= 1'b0;
      waddr_o  <= '0;
      wdata_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_c) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_o    <= 1'b0;
        busy_o  <= 1'b1;
      end else if (stop_c) begin
        state_q <= ST_IDLE;
        oe_o    <= 1'b0;
        busy_o  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              sr_q  <= {sr_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (hit0 || hit1) begin
                bank_o  <= hit1;
                rw_q    <= sr_q[0];
                oe_o    <= 1'b1;
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;  // NACK: leave line released
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= rdata;
                oe_o    <= ~rdata[7];
                ptr_q   <= ptr_q + 1'b1;
                state_q <= ST_RD;
              end else begin
                oe_o     <= 1'b0;
                ptr_ph_q <= 1'b1;
                state_q  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sr_q  <= {sr_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (ptr_ph_q) begin
                ptr_q    <= sr_q;
                ptr_ph_q <= 1'b0;
              end else begin
                wr_en_o <= 1'b1;
                waddr_o <= ptr_q;
                wdata_o <= sr_q;
                ptr_q   <= ptr_q + 1'b1;
              end
              oe_o    <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              oe_o    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                oe_o    <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
                oe_o <= ~tx_q[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q    <= rdata;
                oe_o    <= ~rdata[7];
                ptr_q   <= ptr_q + 1'b1;
                cnt_q   <= '0;
                state_q <= ST_RD;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign raddr_o = ptr_q;
  assign idle_o  = (state_q == ST_IDLE);
endmodule

// File: rtl/dit_reg_bank.sv
module dit_reg_bank
  import dit_pkg::*;
#(
  parameter int unsigned NUM_CTRL = 4,
  parameter int unsigned NUM_STAT = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [BYTE_W-1:0]          waddr_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  input  logic [BYTE_W-1:0]          raddr_i,
  input  logic [NUM_STAT*BYTE_W-1:0] stat_i,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0]          rdata_o
);
  logic [BYTE_W-1:0] ctrl_q [NUM_CTRL];

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q[g] <= '0;
      else if (wr_en_i && waddr_i == BYTE_W'(g)) ctrl_q[g] <= wdata_i;
    end
    assign ctrl_o[g*BYTE_W +: BYTE_W] = ctrl_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (raddr_i == BYTE_W'(i)) rdata_o = ctrl_q[i];
    for (int i = 0; i < NUM_STAT; i++)
      if (raddr_i == BYTE_W'(NUM_CTRL + i)) rdata_o = stat_i[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/dual_i2c_target.sv
module dual_i2c_target
  import dit_pkg::*;
#(
  parameter logic [6:0]  ADDR0       = 7'h2A,
  parameter logic [6:0]  ADDR1       = 7'h4C,
  parameter int unsigned NUM_CTRL    = 4,
  parameter int unsigned NUM_STAT    = 2,
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pair_sel_i,
  input  logic                       scl_a_i,
  input  logic                       sda_a_i,
  output logic                       sda_a_oe_o,
  input  logic                       scl_b_i,
  input  logic                       sda_b_i,
  output logic                       sda_b_oe_o,
  input  logic [NUM_STAT*BYTE_W-1:0] stat0_i,
  input  logic [NUM_STAT*BYTE_W-1:0] stat1_i,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl0_o,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl1_o
);
  localparam int unsigned N_LINES = 4;

  logic [N_LINES-1:0] raw, filt;
  logic               scl_s, sda_s, sel_q, busy, idle, sda_oe;
  logic               bank, wr_en;
  logic [BYTE_W-1:0]  waddr, wdata, raddr, rdata0, rdata1;

  assign raw = {sda_b_i, scl_b_i, sda_a_i, scl_a_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    dit_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  dit_pair_mux u_mux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (pair_sel_i),
    .busy_i    (busy),
    .scl_a_i   (filt[0]),
    .sda_a_i   (filt[1]),
    .scl_b_i   (filt[2]),
    .sda_b_i   (filt[3]),
    .oe_i      (sda_oe),
    .scl_o     (scl_s),
    .sda_o     (sda_s),
    .sda_a_oe_o(sda_a_oe_o),
    .sda_b_oe_o(sda_b_oe_o),
    .sel_q_o   (sel_q)
  );

  dit_proto #(.ADDR0(ADDR0), .ADDR1(ADDR1)) u_proto (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_s),
    .sda_i   (sda_s),
    .rdata0_i(rdata0),
    .rdata1_i(rdata1),
    .oe_o    (sda_oe),
    .busy_o  (busy),
    .idle_o  (idle),
    .bank_o  (bank),
    .wr_en_o (wr_en),
    .waddr_o (waddr),
    .wdata_o (wdata),
    .raddr_o (raddr)
  );

  dit_reg_bank #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_bank0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en & ~bank),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .stat_i (stat0_i),
    .ctrl_o (ctrl0_o),
    .rdata_o(rdata0)
  );

  dit_reg_bank #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_bank1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en & bank),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .stat_i (stat1_i),
    .ctrl_o (ctrl1_o),
    .rdata_o(rdata1)
  );
endmodule

// File: rtl/dit_checker.sv
module dit_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_q_i,
  input logic busy_i,
  input logic idle_i,
  input logic oe_i,
  input logic scl_s_i,
  input logic sda_a_oe_i,
  input logic sda_b_oe_i
);
  assert_oe_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_i) |-> !scl_s_i);

  assert_unsel_a_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q_i |-> !sda_a_oe_i);

  assert_unsel_b_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q_i |-> !sda_b_oe_i);

  assert_sel_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(sel_q_i));

  assert_idle_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !oe_i);
endmodule

bind dual_i2c_target dit_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_q_i   (sel_q),
  .busy_i    (busy),
  .idle_i    (idle),
  .oe_i      (sda_oe),
  .scl_s_i   (scl_s),
  .sda_a_oe_i(sda_a_oe_o),
  .sda_b_oe_i(sda_b_oe_o)
);

// File: tb/dual_i2c_target_tb_top.sv
module dual_i2c_target_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] A0 = 7'h2A, A1 = 7'h4C, ABAD = 7'h11;

  typedef struct packed {
    logic       sel;
    logic       dev;
    logic [7:0] rg;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 8'd0, 8'h11},
    '{1'b0, 1'b1, 8'd0, 8'h22},
    '{1'b1, 1'b0, 8'd1, 8'h33},
    '{1'b1, 1'b1, 8'd3, 8'h44},
    '{1'b0, 1'b0, 8'd4, 8'h99},
    '{1'b1, 1'b1, 8'd5, 8'h77},
    '{1'b0, 1'b1, 8'd9, 8'h66},
    '{1'b1, 1'b0, 8'd3, 8'hF0}
  };

  logic clk = 1'b0, rst_n = 1'b0, pair_sel = 1'b0;
  logic m_scl [2];
  logic m_sda [2];
  logic sda_a_oe, sda_b_oe;
  logic [15:0] stat0 = 16'h5AA5, stat1 = 16'hC33C;
  logic [31:0] ctrl0, ctrl1;
  wire sda_a_bus = m_sda[0] & ~sda_a_oe;
  wire sda_b_bus = m_sda[1] & ~sda_b_oe;

  int checks = 0, fails = 0, pair = 0;
  logic [7:0] mdl [2][4];

  always #10 clk = ~clk;

  dual_i2c_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pair_sel_i(pair_sel),
    .scl_a_i(m_scl[0]), .sda_a_i(sda_a_bus), .sda_a_oe_o(sda_a_oe),
    .scl_b_i(m_scl[1]), .sda_b_i(sda_b_bus), .sda_b_oe_o(sda_b_oe),
    .stat0_i(stat0), .stat1_i(stat1), .ctrl0_o(ctrl0), .ctrl1_o(ctrl1)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    checks++; fails++;
    summary();
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wc(int n); repeat (n) @(negedge clk); endtask

  function automatic logic bus_sda();
    return (pair == 1) ? sda_b_bus : sda_a_bus;
  endfunction

  task automatic i2c_start();
    m_sda[pair] = 1'b1; wc(Q);
    m_scl[pair] = 1'b1; wc(Q);
    m_sda[pair] = 1'b0; wc(Q);
    m_scl[pair] = 1'b0; wc(Q);
  endtask

  task automatic i2c_stop();
    m_sda[pair] = 1'b0; wc(Q);
    m_scl[pair] = 1'b1; wc(Q);
    m_sda[pair] = 1'b1; wc(2*Q);
  endtask

  task automatic wbit(logic b);
    m_sda[pair] = b; wc(Q);
    m_scl[pair] = 1'b1; wc(2*Q);
    m_scl[pair] = 1'b0; wc(Q);
  endtask

  task automatic rbit(output logic b);
    m_sda[pair] = 1'b1; wc(Q);
    m_scl[pair] = 1'b1; wc(Q);
    b = bus_sda(); wc(Q);
    m_scl[pair] = 1'b0; wc(Q);
  endtask

  task automatic wbyte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~give_ack);
  endtask

  function automatic logic [6:0] dev_addr(logic dev);
    return dev ? A1 : A0;
  endfunction

  task automatic wr_regs(logic [6:0] a, logic [7:0] rg, logic [31:0] d, int n, output logic ack);
    logic k;
    i2c_start();
    wbyte({a, 1'b0}, ack);
    wbyte(rg, k);
    for (int i = 0; i < n; i++) wbyte(d[i*8 +: 8], k);
    i2c_stop();
  endtask

  task automatic rd_regs(logic [6:0] a, logic [7:0] rg, int n, output logic [63:0] q);
    logic k;
    logic [7:0] b;
    q = '0;
    i2c_start();
    wbyte({a, 1'b0}, k);
    wbyte(rg, k);
    i2c_start();
    wbyte({a, 1'b1}, k);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, b);
      q[i*8 +: 8] = b;
    end
    i2c_stop();
  endtask

  task automatic set_sel(logic s);
    pair_sel = s; pair = int'(s); wc(8);
  endtask

  function automatic logic [7:0] exp_rd(logic dev, logic [7:0] rg);
    if (rg < 4) return mdl[dev][rg[1:0]];
    if (rg == 4) return dev ? stat1[7:0] : stat0[7:0];
    if (rg == 5) return dev ? stat1[15:8] : stat0[15:8];
    return 8'h00;
  endfunction

  initial begin
    logic ack;
    logic [63:0] q;
    for (int i = 0; i < 2; i++) begin m_scl[i] = 1'b1; m_sda[i] = 1'b1; end
    for (int d = 0; d < 2; d++) for (int r = 0; r < 4; r++) mdl[d][r] = 8'h00;
    wc(5);
    // R12 reset state
    check("R12 ctrl0", 64'(ctrl0), 64'h0);
    check("R12 ctrl1", 64'(ctrl1), 64'h0);
    check("R12 oe", 64'({sda_a_oe, sda_b_oe}), 64'h0);
    rst_n = 1'b1;
    wc(5);

    // vector table: R1 R2 R6 R7 R8 single write then read back
    foreach (VECS[v]) begin
      set_sel(VECS[v].sel);
      wr_regs(dev_addr(VECS[v].dev), VECS[v].rg, 32'(VECS[v].data), 1, ack);
      check("R1/R2 addr ack", 64'(ack), 64'h1);
      if (VECS[v].rg < 4) mdl[VECS[v].dev][VECS[v].rg[1:0]] = VECS[v].data;
      rd_regs(dev_addr(VECS[v].dev), VECS[v].rg, 1, q);
      check("R6/R7 readback", q, 64'(exp_rd(VECS[v].dev, VECS[v].rg)));
      check("R1 ctrl0 port", 64'(ctrl0), 64'({mdl[0][3], mdl[0][2], mdl[0][1], mdl[0][0]}));
      check("R2 ctrl1 port", 64'(ctrl1), 64'({mdl[1][3], mdl[1][2], mdl[1][1], mdl[1][0]}));
    end

    // R4 auto-increment write
    set_sel(1'b0);
    wr_regs(A1, 8'd0, 32'h04030201, 4, ack);
    for (int r = 0; r < 4; r++) mdl[1][r] = 8'(r + 1);
    check("R4 burst write", 64'(ctrl1), 64'h04030201);
    check("R2 bank0 untouched", 64'(ctrl0), 64'({mdl[0][3], mdl[0][2], mdl[0][1], mdl[0][0]}));

    // R5 burst read
    rd_regs(A1, 8'd0, 4, q);
    check("R5 burst read", q, 64'h04030201);

    // R6 R7 read across status and unimplemented
    rd_regs(A0, 8'd2, 6, q);
    check("R6/R7 span read", q, {16'h0000, stat0, mdl[0][3], mdl[0][2]});

    // R3 unmatched address
    wr_regs(ABAD, 8'd0, 32'h000000EE, 1, ack);
    check("R3 nack", 64'(ack), 64'h0);
    check("R3 no change", 64'(ctrl0), 64'({mdl[0][3], mdl[0][2], mdl[0][1], mdl[0][0]}));

    // R8 traffic on unselected pair B
    pair = 1;
    wr_regs(A0, 8'd0, 32'h000000DD, 1, ack);
    check("R8 unselected nack", 64'(ack), 64'h0);
    check("R8 unselected no write", 64'(ctrl0[7:0]), 64'(mdl[0][0]));
    pair = 0;

    // R9 select change mid-frame
    i2c_start();
    wbyte({A0, 1'b0}, ack);
    pair_sel = 1'b1;
    wbyte(8'd2, ack);
    wbyte(8'hB7, ack);
    check("R9 ack after mid-frame select", 64'(ack), 64'h1);
    i2c_stop();
    wc(8);
    mdl[0][2] = 8'hB7;
    check("R9 write completed", 64'(ctrl0[23:16]), 64'hB7);
    wr_regs(A0, 8'd2, 32'h000000CC, 1, ack);
    check("R9 old pair ignored after stop", 64'(ack), 64'h0);
    pair = 1;
    wr_regs(A0, 8'd2, 32'h000000CC, 1, ack);
    check("R9 new pair active", 64'(ack), 64'h1);
    mdl[0][2] = 8'hCC;

    // R10 short clock glitch
    i2c_start();
    wbyte({A0, 1'b0}, ack);
    m_scl[pair] = 1'b1; wc(2);
    m_scl[pair] = 1'b0; wc(Q);
    wbyte(8'd1, ack);
    wbyte(8'h5E, ack);
    i2c_stop();
    mdl[0][1] = 8'h5E;
    check("R10 glitch filtered", 64'(ctrl0), 64'({mdl[0][3], mdl[0][2], mdl[0][1], mdl[0][0]}));

    summary();
  end
endmodule